// File: doc/BRIEF.md
# Masked Interrupt Concentrator with Board Identity Register

This block gathers eight peripheral interrupt request lines on a board-level logic device and folds them into one active-low request that feeds a processor input pin which reacts to falling edges. Each request line is brought into the clock domain through a two-stage synchronizer. A rising edge on a synchronized line latches a bit in a pending register. A per-source enable mask decides which latched bits may pull the combined request low.

Software talks to the block over a plain synchronous register bus with an address, a write strobe, write data and combinational read data. It reads the pending bits and clears them all at once by writing zero. It enables sources through the mask register. Because the processor reacts only to edges, software can force a fresh falling edge by writing an all-zero mask and then writing the old mask back. A read-only identity register reports the baseboard, expansion-card and processor-card codes as three 4-bit fields.

The combined output is driven by a two-state machine. In state QUIET the output is high. In state REQUEST it is low. The machine moves from QUIET to REQUEST when any pending bit is enabled (transition RAISE). It moves from REQUEST back to QUIET when no pending bit is enabled (transition DROP). In every other case it holds its state.

Top module: `irq_concentrator`

## Requirements
- R1: After reset the pending register and the mask register read 0, and `req_n` is 1.
- R2: A rising edge on `src_req[i]` sets pending bit i on the third clock edge after the input rises. This delay comes from two synchronizer stages and one edge stage. The bit then stays set while the input stays high, and it also stays set after the input falls.
- R3: A read at offset 0x0 returns the pending bits in bits 7:0, with bits 15:8 reading as zero.
- R4: A write of 0x0000 to offset 0x0 clears every pending bit on that clock edge. A write of any nonzero value to offset 0x0 leaves the pending bits unchanged.
- R5: A source edge that would set a pending bit on the same clock edge as a clear write still leaves that bit set.
- R6: A write to offset 0x4 loads bits 7:0 of the write data into the mask. A bit value of 1 enables that source. A read at offset 0x4 returns the mask in bits 7:0, with the upper bits reading as zero.
- R7: `req_n` is 0 one clock after the AND of pending and mask is nonzero, and it is 1 one clock after that AND is zero.
- R8: While the mask is all zero, `req_n` is 1 from the next clock on, whatever the pending bits hold.
- R9: Writing mask 0 and then writing the earlier mask back, while an enabled pending bit stays set, makes `req_n` go high and then fall again.
- R10: A read at offset 0x8 returns the baseboard code in bits 11:8, the expansion code in bits 7:4 and the processor-card code in bits 3:0, with bits 15:12 reading as zero. The default baseboard code is 8.
- R11: A read at any offset other than 0x0, 0x4 or 0x8 returns 0. A write to offset 0x8 or to any unmapped offset changes neither the pending bits nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| src_req | input | 8 | Peripheral interrupt request lines, asynchronous |
| req_n | output | 1 | Combined request to the processor, active low |

## Verification
A clear-by-zero write and a freshly detected source edge can arrive on the same clock edge, and in that case the edge must win for its own bit. The bench provokes this collision on purpose. It raises a source and then, two falling edges later, presents the clear write, so the write lands exactly on the cycle when the edge is captured. It then judges the result by reading bit 3 back at offset 0x0 and by watching `req_n` fall. The random phase makes many more such collisions by mixing frequent zero writes with toggling sources. Every cycle of that phase is compared against a cycle-accurate model in the bench.

// File: rtl/irq_conc_pkg.sv
package irq_conc_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_PEND = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MASK = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_ID   = 4'h8;

    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_REQUEST = 1'b1
    } req_state_t;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_in,
    output logic [NSRC-1:0] rise_pulse
);
    logic [NSRC-1:0] meta_q;
    logic [NSRC-1:0] sync_q;
    logic [NSRC-1:0] hist_q;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[gi] <= 1'b0;
                    sync_q[gi] <= 1'b0;
                    hist_q[gi] <= 1'b0;
                end else begin
                    meta_q[gi] <= raw_in[gi];
                    sync_q[gi] <= meta_q[gi];
                    hist_q[gi] <= sync_q[gi];
                end
            end
            assign rise_pulse[gi] = sync_q[gi] & ~hist_q[gi];
        end
    endgenerate
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_pulse,
    input  logic            clear_all,
    output logic [NSRC-1:0] pend_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q[gi] <= 1'b0;
                end else if (set_pulse[gi]) begin
                    pend_q[gi] <= 1'b1;
                end else if (clear_all) begin
                    pend_q[gi] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic req_n
);
    import irq_conc_pkg::*;

    req_state_t state_q;
    req_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (active)  state_d = ST_REQUEST;
            ST_REQUEST: if (!active) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        req_n = (state_q != ST_REQUEST);
    end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator #(
    parameter int         NSRC     = 8,
    parameter logic [3:0] BOARD_ID = 4'd8,
    parameter logic [3:0] EXPAN_ID = 4'd2,
    parameter logic [3:0] CARD_ID  = 4'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [7:0]  src_req,
    output logic        req_n
);
    import irq_conc_pkg::*;

    localparam int PAD_W = DATA_W - NSRC;
    localparam logic [DATA_W-1:0] ID_WORD = {4'h0, BOARD_ID, EXPAN_ID, CARD_ID};

    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic            clr_wr;
    logic            mask_wr;

    assign clr_wr  = bus_we && (bus_addr == OFS_PEND) && (bus_wdata == '0);
    assign mask_wr = bus_we && (bus_addr == OFS_MASK);

    irq_edge_capture #(.NSRC(NSRC)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (src_req),
        .rise_pulse (rise)
    );

    irq_pending_bank #(.NSRC(NSRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (rise),
        .clear_all (clr_wr),
        .pend_q    (pend_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= bus_wdata[NSRC-1:0];
    end

    irq_req_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (|(pend_q & mask_q)),
        .req_n  (req_n)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_PEND: bus_rdata = {{PAD_W{1'b0}}, pend_q};
            OFS_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
            OFS_ID:   bus_rdata = ID_WORD;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_conc_chk.sv
module irq_conc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_we,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic [7:0]  pend_q,
    input logic [7:0]  mask_q,
    input logic        req_n
);
    a_r7_assert_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & mask_q)) |=> !req_n);
    a_r7_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_q & mask_q)) |=> req_n);
    a_r8_mask_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |=> req_n);
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'h4) |=> (mask_q == $past(bus_wdata[7:0])));
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 4'h0 && bus_wdata == 16'h0000)
        |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 4'h0 && bus_addr != 4'h4 && bus_addr != 4'h8) |-> (bus_rdata == 16'h0000));
endmodule

bind irq_concentrator irq_conc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .req_n     (req_n)
);

// File: tb/sim_irq_concentrator.sv
`timescale 1ns/1ps
module sim_irq_concentrator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  src_req = 8'h0;
    logic        req_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_concentrator u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req), .req_n(req_n)
    );

    // cycle model built from the requirements
    logic [7:0] m_s1, m_s2, m_s3, m_pend, m_mask;
    logic       m_req_n;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_pend <= 0; m_mask <= 0; m_req_n <= 1'b1;
        end else begin
            m_s1 <= src_req;
            m_s2 <= m_s1;
            m_s3 <= m_s2;
            m_pend <= ((bus_we && bus_addr == 4'h0 && bus_wdata == 16'h0) ? 8'h00 : m_pend)
                      | (m_s2 & ~m_s3);
            if (bus_we && bus_addr == 4'h4) m_mask <= bus_wdata[7:0];
            m_req_n <= ((m_pend & m_mask) == 8'h00);
        end
    end

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0: return {8'h00, m_pend};
            4'h4: return {8'h00, m_mask};
            4'h8: return 16'h0821;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'h0: return "R3";
            4'h4: return "R6";
            4'h8: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc_model();
        @(posedge clk);
        @(negedge clk);
        check("R7 req_n", {15'd0, req_n}, {15'd0, m_req_n});
        check(rd_tag(bus_addr), bus_rdata, exp_read(bus_addr));
    endtask

    task automatic idle_bus();
        bus_we = 0; bus_addr = 4'h0; bus_wdata = 16'h0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        cyc_model();
        idle_bus();
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
        bus_we = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rd_check("R1 pending", 4'h0, 16'h0000);
        rd_check("R1 mask", 4'h4, 16'h0000);
        check("R1 req_n", {15'd0, req_n}, 16'h0001);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 and R11 reads, writes to ID and unmapped offsets ignored
        rd_check("R10 id", 4'h8, 16'h0821);
        rd_check("R11 unmapped", 4'hC, 16'h0000);
        wr(4'h8, 16'hFFFF);
        wr(4'hC, 16'h00FF);
        rd_check("R11 mask untouched", 4'h4, 16'h0000);

        // R2: rise lands on third edge
        src_req[2] = 1'b1;
        cyc_model(); cyc_model();
        rd_check("R2 not yet", 4'h0, 16'h0000);
        cyc_model();
        rd_check("R2 set", 4'h0, 16'h0004);
        src_req[2] = 1'b0;
        repeat (3) cyc_model();
        rd_check("R2 stays after fall", 4'h0, 16'h0004);

        // R8: pending but mask zero keeps req_n high
        check("R8 req_n high", {15'd0, req_n}, 16'h0001);

        // R6/R7: enable source 2
        wr(4'h4, 16'hAB04);
        rd_check("R6 mask readback", 4'h4, 16'h0004);
        cyc_model();
        check("R7 req_n low", {15'd0, req_n}, 16'h0000);

        // R9: re-arm sequence
        wr(4'h4, 16'h0000);
        cyc_model();
        check("R9 req_n high during zero mask", {15'd0, req_n}, 16'h0001);
        wr(4'h4, 16'h0004);
        cyc_model();
        check("R9 req_n falls again", {15'd0, req_n}, 16'h0000);

        // R4: nonzero write ignored, zero write clears
        wr(4'h0, 16'h0100);
        rd_check("R4 nonzero write ignored", 4'h0, 16'h0004);
        wr(4'h0, 16'h0000);
        rd_check("R4 cleared", 4'h0, 16'h0000);
        cyc_model();
        check("R7 req_n high after clear", {15'd0, req_n}, 16'h0001);

        // R5: edge captured on the same edge as a clear write
        wr(4'h4, 16'h0008);
        src_req[3] = 1'b1;
        cyc_model(); cyc_model();
        wr(4'h0, 16'h0000);
        rd_check("R5 edge survives clear", 4'h0, 16'h0008);
        cyc_model();
        check("R5 req_n low", {15'd0, req_n}, 16'h0000);
        src_req[3] = 1'b0;
        wr(4'h0, 16'h0000);

        // random phase against model
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] addrs [5];
            addrs[0] = 4'h0; addrs[1] = 4'h4; addrs[2] = 4'h8; addrs[3] = 4'h2; addrs[4] = 4'hC;
            for (int b = 0; b < 8; b++)
                if ($urandom_range(0, 9) == 0) src_req[b] = ~src_req[b];
            bus_addr = addrs[$urandom_range(0, 4)];
            bus_we = ($urandom_range(0, 3) == 0);
            bus_wdata = ($urandom_range(0, 1) == 0) ? 16'h0000 : 16'($urandom());
            cyc_model();
        end
        idle_bus();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule